// File: doc/BRIEF.md
# Pipeline Interlock and Branch Squash Controller

This block is the hazard control for a five-stage fetch / decode / execute / memory / write-back pipeline that has no operand forwarding. It owns the program counter, the valid bit of the fetch-to-decode register, and a control-only shadow of the three later pipeline registers. Each of these registers carries the register-write, destination, memory-write and memory-read fields of one instruction. Decode supplies the source register numbers of the instruction it holds, together with their use flags, its control fields, its two register-file read values and its branch target.

When a source of the decoding instruction matches the destination of an older instruction that writes a register and is still in flight, the block stalls. It freezes the PC and the decode slot and drops an all-zero control bubble into the execute stage, while older instructions keep moving. How many older stages are compared depends on whether the register file passes a same-cycle write through to its read ports. With pass-through, an adjacent dependency costs two bubbles; without it, three.

Conditional equal-branches are resolved in decode under a predict-not-taken policy. On a taken branch, only the one instruction fetched behind the branch is squashed. A stall always overrides a branch decision, and the branch is evaluated again once its operands are safe. All interface pins are plain level signals sampled each cycle: there is no stream handshake, so there are no back-pressure rules.

Top module: `hzd_ctl_unit`

## Requirements
- R1: While rst_n is low, pc_o equals RESET_PC (default 0), id_valid_o is 0, stall_o and squash_o are 0, and every execute, memory and write-back control output is 0.
- R2: In a cycle with no stall and no squash, pc_o advances by PC_STEP (default 4) at the next rising edge, and id_valid_o becomes 1.
- R3: A dependency exists when id_valid_o is 1 and a used source (rs with rs_used, rt with rt_used) equals the destination of the execute or memory stage whose register-write bit is 1. A dependency raises stall_o, and at the next edge pc_o is unchanged and id_valid_o stays 1.
- R4: In the edge after a stall cycle, or after a cycle with id_valid_o at 0, all execute-stage control outputs are 0. Instructions already in the execute and memory stages still move on one stage.
- R5: With RF_BYPASS=1, a write-back stage producer causes no stall, so an adjacent dependency costs two stall cycles. With RF_BYPASS=0, the write-back stage is compared as well, and the same dependency costs three.
- R6: A match on register number 0 never causes a stall.
- R7: A source whose use flag is 0 never causes a stall, even when its number matches an in-flight destination.
- R8: When id_valid_o is 1, dec_beq_i is 1, there is no stall, and dec_opa_i equals dec_opb_i in every bit, squash_o is 1. pc_o then takes dec_target_i at the next edge and id_valid_o becomes 0, so exactly one fetched instruction is discarded. With id_valid_o at 0, a branch request has no effect.
- R9: A branch whose operands differ in any bit gives squash_o at 0, and fetch continues at pc_o plus PC_STEP.
- R10: If a branch would be taken while stall_o is 1, squash_o stays 0. The branch is taken in the first cycle without a stall.
- R11: The control fields of a valid, non-stalled decode instruction appear on the execute outputs after one edge, on the memory outputs after two, and on the write-back outputs after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_rs_i | input | REG_AW | First source register number in decode |
| dec_rt_i | input | REG_AW | Second source register number in decode |
| dec_rs_used_i | input | 1 | First source is read |
| dec_rt_used_i | input | 1 | Second source is read |
| dec_reg_we_i | input | 1 | Decode instruction writes a register |
| dec_dst_i | input | REG_AW | Decode instruction destination register |
| dec_mem_wr_i | input | 1 | Decode instruction writes memory |
| dec_mem_rd_i | input | 1 | Decode instruction reads memory |
| dec_beq_i | input | 1 | Decode instruction is a branch-if-equal |
| dec_opa_i | input | XLEN | First register-file read value |
| dec_opb_i | input | XLEN | Second register-file read value |
| dec_target_i | input | XLEN | Branch target address |
| pc_o | output | XLEN | Fetch address |
| id_valid_o | output | 1 | Decode slot holds a live instruction |
| stall_o | output | 1 | Dependency stall this cycle |
| squash_o | output | 1 | Taken branch; fetched instruction discarded |
| ex_reg_we_o | output | 1 | Execute stage register-write bit |
| ex_dst_o | output | REG_AW | Execute stage destination |
| ex_mem_wr_o | output | 1 | Execute stage memory-write bit |
| ex_mem_rd_o | output | 1 | Execute stage memory-read bit |
| mem_reg_we_o | output | 1 | Memory stage register-write bit |
| mem_dst_o | output | REG_AW | Memory stage destination |
| mem_mem_wr_o | output | 1 | Memory stage memory-write bit |
| mem_mem_rd_o | output | 1 | Memory stage memory-read bit |
| wb_reg_we_o | output | 1 | Write-back stage register-write bit |
| wb_dst_o | output | REG_AW | Write-back stage destination |

## Verification
The bench builds two copies side by side: the default with RF_BYPASS=1, and a second with RF_BYPASS=0, sharing reset and stimulus. The first copy carries the full scoreboard of PC, decode-valid, stall, squash and the three stage control sets. This covers register-0 and unused-source matches, taken and untaken branches, a branch request in a squashed slot, and a branch held behind a stall. The second copy brings the write-back comparison into reach, so that the two-bubble and three-bubble counts for the same adjacent dependency are checked in the same cycles.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  parameter int unsigned REG_AW = 5;
  localparam int unsigned NSTG = 3;  // execute, memory, write-back

  typedef struct packed {
    logic              reg_we;
    logic [REG_AW-1:0] dst;
    logic              mem_wr;
    logic              mem_rd;
  } stage_ctl_t;

  localparam stage_ctl_t CTL_NOP = '0;
endpackage

// File: rtl/hzd_dep_check.sv
module hzd_dep_check
  import hzd_pkg::*;
#(
  parameter int unsigned RF_BYPASS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] rs,
  input  logic [REG_AW-1:0] rt,
  input  logic              rs_used,
  input  logic              rt_used,
  input  stage_ctl_t        older [NSTG],
  output logic              hazard
);
  // write-back slot is compared only when the register file has no pass-through
  localparam logic [NSTG-1:0] CHK_MASK = (RF_BYPASS != 0) ? 3'b011 : 3'b111;

  logic [NSTG-1:0] hit_rs, hit_rt;

  for (genvar g = 0; g < NSTG; g++) begin : g_cmp
    assign hit_rs[g] = older[g].reg_we && (older[g].dst == rs) && (rs != '0);
    assign hit_rt[g] = older[g].reg_we && (older[g].dst == rt) && (rt != '0);
  end

  assign hazard = id_valid && ((rs_used && |(hit_rs & CHK_MASK)) ||
                               (rt_used && |(hit_rt & CHK_MASK)));

  AST_ZERO_REG_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((rs == '0 || !rs_used) && (rt == '0 || !rt_used)) |-> !hazard); // R6
endmodule

// File: rtl/hzd_br_cmp.sv
module hzd_br_cmp #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_valid,
  input  logic            is_beq,
  input  logic            hazard,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            take
);
  logic [XLEN-1:0] same;
  logic            eq;

  for (genvar g = 0; g < XLEN; g++) begin : g_bit
    assign same[g] = ~(opa[g] ^ opb[g]);
  end
  assign eq = &same;

  // stall wins: the branch waits until its operands are safe
  assign take = id_valid && is_beq && !hazard && eq;

  AST_STALL_BEATS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> !take); // R10
endmodule

// File: rtl/hzd_pc_gen.sv
module hzd_pc_gen #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned PC_STEP  = 4,
  parameter int unsigned RESET_PC = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            take,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc,
  output logic            id_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= XLEN'(RESET_PC);
      id_valid <= 1'b0;
    end else if (!stall) begin
      pc       <= take ? target : pc + XLEN'(PC_STEP);
      id_valid <= !take;
    end
  end

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(pc) && id_valid)); // R3
  AST_ONE_SQUASHED: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !id_valid); // R8
endmodule

// File: rtl/hzd_ctl_pipe.sv
module hzd_ctl_pipe
  import hzd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stall,
  input  logic       id_valid,
  input  stage_ctl_t dec_ctl,
  output stage_ctl_t ex_ctl,
  output stage_ctl_t mem_ctl,
  output stage_ctl_t wb_ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_ctl  <= CTL_NOP;
      mem_ctl <= CTL_NOP;
      wb_ctl  <= CTL_NOP;
    end else begin
      ex_ctl  <= (stall || !id_valid) ? CTL_NOP : dec_ctl;
      mem_ctl <= ex_ctl;
      wb_ctl  <= mem_ctl;
    end
  end

  AST_BUBBLE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || !id_valid) |=> (ex_ctl == CTL_NOP)); // R4
endmodule

// File: rtl/hzd_ctl_unit.sv
module hzd_ctl_unit
  import hzd_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned PC_STEP   = 4,
  parameter int unsigned RESET_PC  = 0,
  parameter int unsigned RF_BYPASS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] dec_rs_i,
  input  logic [REG_AW-1:0] dec_rt_i,
  input  logic              dec_rs_used_i,
  input  logic              dec_rt_used_i,
  input  logic              dec_reg_we_i,
  input  logic [REG_AW-1:0] dec_dst_i,
  input  logic              dec_mem_wr_i,
  input  logic              dec_mem_rd_i,
  input  logic              dec_beq_i,
  input  logic [XLEN-1:0]   dec_opa_i,
  input  logic [XLEN-1:0]   dec_opb_i,
  input  logic [XLEN-1:0]   dec_target_i,
  output logic [XLEN-1:0]   pc_o,
  output logic              id_valid_o,
  output logic              stall_o,
  output logic              squash_o,
  output logic              ex_reg_we_o,
  output logic [REG_AW-1:0] ex_dst_o,
  output logic              ex_mem_wr_o,
  output logic              ex_mem_rd_o,
  output logic              mem_reg_we_o,
  output logic [REG_AW-1:0] mem_dst_o,
  output logic              mem_mem_wr_o,
  output logic              mem_mem_rd_o,
  output logic              wb_reg_we_o,
  output logic [REG_AW-1:0] wb_dst_o
);
  stage_ctl_t dec_ctl, ex_ctl, mem_ctl, wb_ctl;
  stage_ctl_t older [NSTG];
  logic       hazard, take, id_valid;

  assign dec_ctl = '{reg_we: dec_reg_we_i, dst: dec_dst_i,
                     mem_wr: dec_mem_wr_i, mem_rd: dec_mem_rd_i};
  assign older[0] = ex_ctl;
  assign older[1] = mem_ctl;
  assign older[2] = wb_ctl;

  hzd_dep_check #(.RF_BYPASS(RF_BYPASS)) u_dep (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
    .rs(dec_rs_i), .rt(dec_rt_i),
    .rs_used(dec_rs_used_i), .rt_used(dec_rt_used_i),
    .older(older), .hazard(hazard)
  );

  hzd_br_cmp #(.XLEN(XLEN)) u_br (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .is_beq(dec_beq_i),
    .hazard(hazard), .opa(dec_opa_i), .opb(dec_opb_i), .take(take)
  );

  hzd_pc_gen #(.XLEN(XLEN), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .stall(hazard), .take(take),
    .target(dec_target_i), .pc(pc_o), .id_valid(id_valid)
  );

  hzd_ctl_pipe u_pipe (
    .clk(clk), .rst_n(rst_n), .stall(hazard), .id_valid(id_valid),
    .dec_ctl(dec_ctl), .ex_ctl(ex_ctl), .mem_ctl(mem_ctl), .wb_ctl(wb_ctl)
  );

  assign id_valid_o   = id_valid;
  assign stall_o      = hazard;
  assign squash_o     = take;
  assign ex_reg_we_o  = ex_ctl.reg_we;
  assign ex_dst_o     = ex_ctl.dst;
  assign ex_mem_wr_o  = ex_ctl.mem_wr;
  assign ex_mem_rd_o  = ex_ctl.mem_rd;
  assign mem_reg_we_o = mem_ctl.reg_we;
  assign mem_dst_o    = mem_ctl.dst;
  assign mem_mem_wr_o = mem_ctl.mem_wr;
  assign mem_mem_rd_o = mem_ctl.mem_rd;
  assign wb_reg_we_o  = wb_ctl.reg_we;
  assign wb_dst_o     = wb_ctl.dst;
endmodule

// File: tb/hzd_ctl_unit_tb_top.sv
module hzd_ctl_unit_tb_top;
  import hzd_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  rs, rt, dst;
  logic        rsu, rtu, we, mwr, mrd, beq;
  logic [31:0] opa, opb, tgt;

  logic [31:0] pc;
  logic        idv, stall, squash, ex_we, ex_mw, ex_mr, mem_we, mem_mw, mem_mr, wb_we;
  logic [4:0]  ex_dst, mem_dst, wb_dst;
  logic [31:0] nb_pc;
  logic        nb_idv, nb_stall, nb_squash, nb_ex_we, nb_ex_mw, nb_ex_mr;
  logic        nb_mem_we, nb_mem_mw, nb_mem_mr, nb_wb_we;
  logic [4:0]  nb_ex_dst, nb_mem_dst, nb_wb_dst;

  hzd_ctl_unit #(.RF_BYPASS(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .dec_rs_i(rs), .dec_rt_i(rt),
    .dec_rs_used_i(rsu), .dec_rt_used_i(rtu), .dec_reg_we_i(we), .dec_dst_i(dst),
    .dec_mem_wr_i(mwr), .dec_mem_rd_i(mrd), .dec_beq_i(beq),
    .dec_opa_i(opa), .dec_opb_i(opb), .dec_target_i(tgt),
    .pc_o(pc), .id_valid_o(idv), .stall_o(stall), .squash_o(squash),
    .ex_reg_we_o(ex_we), .ex_dst_o(ex_dst), .ex_mem_wr_o(ex_mw), .ex_mem_rd_o(ex_mr),
    .mem_reg_we_o(mem_we), .mem_dst_o(mem_dst), .mem_mem_wr_o(mem_mw), .mem_mem_rd_o(mem_mr),
    .wb_reg_we_o(wb_we), .wb_dst_o(wb_dst));

  hzd_ctl_unit #(.RF_BYPASS(0)) dut_nb_i (
    .clk(clk), .rst_n(rst_n), .dec_rs_i(rs), .dec_rt_i(rt),
    .dec_rs_used_i(rsu), .dec_rt_used_i(rtu), .dec_reg_we_i(we), .dec_dst_i(dst),
    .dec_mem_wr_i(mwr), .dec_mem_rd_i(mrd), .dec_beq_i(beq),
    .dec_opa_i(opa), .dec_opb_i(opb), .dec_target_i(tgt),
    .pc_o(nb_pc), .id_valid_o(nb_idv), .stall_o(nb_stall), .squash_o(nb_squash),
    .ex_reg_we_o(nb_ex_we), .ex_dst_o(nb_ex_dst), .ex_mem_wr_o(nb_ex_mw), .ex_mem_rd_o(nb_ex_mr),
    .mem_reg_we_o(nb_mem_we), .mem_dst_o(nb_mem_dst), .mem_mem_wr_o(nb_mem_mw),
    .mem_mem_rd_o(nb_mem_mr), .wb_reg_we_o(nb_wb_we), .wb_dst_o(nb_wb_dst));

  typedef struct {
    string      req;
    logic [31:0] pc;
    logic       idv, stall, squash, chk_nb, nb_stall;
    stage_ctl_t ex, mem, wb;
  } exp_t;

  exp_t       sb_q[$];
  int         n_chk = 0, n_fail = 0;
  logic [31:0] m_pc;
  logic       m_idv;
  stage_ctl_t m_ex, m_mem, m_wb;

  function automatic stage_ctl_t mk(input logic w, input logic [4:0] d,
                                    input logic sw, input logic lr);
    mk = '{reg_we: w, dst: d, mem_wr: sw, mem_rd: lr};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per driven cycle, before the next edge
  always @(negedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.req, "pc", pc, e.pc);
      check(e.req, "id_valid", 32'(idv), 32'(e.idv));
      check(e.req, "stall", 32'(stall), 32'(e.stall));
      check(e.req, "squash", 32'(squash), 32'(e.squash));
      check(e.req, "ex ctl", 32'(mk(ex_we, ex_dst, ex_mw, ex_mr)), 32'(e.ex));
      check(e.req, "mem ctl", 32'(mk(mem_we, mem_dst, mem_mw, mem_mr)), 32'(e.mem));
      check(e.req, "wb ctl", 32'({wb_we, wb_dst}), 32'({e.wb.reg_we, e.wb.dst}));
      if (e.chk_nb) check(e.req, "no-bypass stall", 32'(nb_stall), 32'(e.nb_stall));
    end
  end

  task automatic push_exp(input string req, input logic xs, input logic xq,
                          input logic cnb, input logic nbs);
    exp_t e;
    e.req = req; e.pc = m_pc; e.idv = m_idv; e.stall = xs; e.squash = xq;
    e.chk_nb = cnb; e.nb_stall = nbs; e.ex = m_ex; e.mem = m_mem; e.wb = m_wb;
    sb_q.push_back(e);
  endtask

  task automatic set_in(input logic [4:0] s1, input logic u1, input logic [4:0] s2,
                        input logic u2, input stage_ctl_t c, input logic b,
                        input logic [31:0] a, input logic [31:0] o, input logic [31:0] t);
    rs = s1; rsu = u1; rt = s2; rtu = u2;
    we = c.reg_we; dst = c.dst; mwr = c.mem_wr; mrd = c.mem_rd;
    beq = b; opa = a; opb = o; tgt = t;
  endtask

  // driver: one decode cycle; expected outputs from the requirements
  task automatic drive(input string req, input logic [4:0] s1, input logic u1,
                       input logic [4:0] s2, input logic u2, input stage_ctl_t c,
                       input logic b, input logic [31:0] a, input logic [31:0] o,
                       input logic [31:0] t, input logic xs, input logic xq,
                       input logic cnb, input logic nbs);
    @(negedge clk);
    set_in(s1, u1, s2, u2, c, b, a, o, t);
    push_exp(req, xs, xq, cnb, nbs);
    m_wb  = m_mem;
    m_mem = m_ex;
    m_ex  = (xs || !m_idv) ? CTL_NOP : c;
    if (!xs) begin
      m_pc  = xq ? t : m_pc + 32'd4;
      m_idv = !xq;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    set_in(0, 0, 0, 0, CTL_NOP, 0, 0, 0, 0);
    m_pc = 0; m_idv = 0; m_ex = CTL_NOP; m_mem = CTL_NOP; m_wb = CTL_NOP;
    push_exp("R1", 0, 0, 1, 0);
    @(negedge clk);
    push_exp("R1", 0, 0, 1, 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = 32'd4; m_idv = 1'b1;  // one edge with an empty decode slot
  endtask

  logic done = 1'b0;

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    set_in(0, 0, 0, 0, CTL_NOP, 0, 0, 0, 0);
    // phase A: full scoreboard on the pass-through copy
    do_reset();
    drive("R2",  1, 1, 3, 1, mk(1, 2, 0, 0), 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R3",  2, 1, 5, 1, mk(1, 9, 0, 1), 0, 0, 0, 0, 1, 0, 0, 0);
    drive("R4",  2, 1, 5, 1, mk(1, 9, 0, 1), 0, 0, 0, 0, 1, 0, 0, 0);
    drive("R5",  2, 1, 5, 1, mk(1, 9, 0, 1), 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R7",  9, 0, 7, 1, mk(1, 0, 0, 0), 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R6",  0, 1, 0, 1, mk(0, 0, 1, 0), 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R9",  4, 1, 6, 1, CTL_NOP, 1, 32'h1234, 32'h1235, 32'h80, 0, 0, 0, 0);
    drive("R8",  4, 1, 6, 1, CTL_NOP, 1, 32'hABCD, 32'hABCD, 32'h100, 0, 1, 0, 0);
    drive("R8",  9, 1, 0, 0, mk(1, 5, 0, 0), 1, 32'h5, 32'h5, 32'h200, 0, 0, 0, 0);
    drive("R11", 0, 0, 0, 0, mk(1, 3, 0, 0), 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R10", 3, 1, 0, 1, CTL_NOP, 1, 32'h5, 32'h5, 32'h300, 1, 0, 0, 0);
    drive("R10", 3, 1, 0, 1, CTL_NOP, 1, 32'h5, 32'h5, 32'h300, 1, 0, 0, 0);
    drive("R10", 3, 1, 0, 1, CTL_NOP, 1, 32'h5, 32'h5, 32'h300, 0, 1, 0, 0);
    drive("R11", 0, 0, 0, 0, CTL_NOP, 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R11", 0, 0, 0, 0, CTL_NOP, 0, 0, 0, 0, 0, 0, 0, 0);
    // phase B: bubble count with and without pass-through
    do_reset();
    drive("R5",  1, 1, 3, 1, mk(1, 2, 0, 0), 0, 0, 0, 0, 0, 0, 1, 0);
    drive("R5",  2, 1, 5, 1, CTL_NOP, 0, 0, 0, 0, 1, 0, 1, 1);
    drive("R5",  2, 1, 5, 1, CTL_NOP, 0, 0, 0, 0, 1, 0, 1, 1);
    drive("R5",  2, 1, 5, 1, CTL_NOP, 0, 0, 0, 0, 0, 0, 1, 1);
    drive("R5",  2, 1, 5, 1, CTL_NOP, 0, 0, 0, 0, 0, 0, 1, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule